// File: doc/BRIEF.md
# RAM-Backed Programmable Sample Delay

This block delays a stream of samples by a programmable number of clock-enabled cycles. It keeps the samples in a single-port synchronous memory, not in a chain of registers. A modulo address counter sweeps the memory. On every enabled cycle the port returns the word held at the current address and stores the incoming sample at that same address. A word therefore comes back out one full sweep after it went in. For delays of a few hundred samples this costs far less than a flip-flop chain.

The length input is a 10-bit unsigned terminal count `L`. The counter runs 0..L, so one sweep lasts L+1 cycles. An input register and an output register are added around the memory port. Together they give a fixed overhead, and the total delay is L+3 enabled cycles. A caller that wants a delay of N samples programs L = N-3.

The delay is defined as a clean history. After reset, and after any change of the length input, the output stays zero until real samples come back out.

Top module: `ram_sample_delay`

## Requirements
- R1: With the length input held at L and the clock enable high, the sample presented at enabled cycle k appears on the output after enabled cycle k+L+3. The delay is L+3 cycles for every legal L.
- R2: The length input is an unsigned 10-bit terminal count. The memory address steps 0,1,..,L and then returns to 0. The smallest value, L=0, gives a delay of exactly 3 enabled cycles.
- R3: While the clock enable is low and the length is unchanged, the output and the address hold their values. No sample is consumed. Delay is counted in enabled cycles only.
- R4: After a restart, the output is zero for the first L+3 enabled cycles. Stale memory contents never reach the output.
- R5: On any clock edge where the length input differs from the stored length, the block restarts, whatever the enable is doing. The new length is stored, the address goes to 0, the history is cleared and the output becomes zero.
- R6: While the active-low reset is asserted, the output is zero and the address is 0.
- R7: The largest value, L=1023, gives a delay of 1026 enabled cycles across all 1024 memory words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; one sample is taken per enabled cycle |
| lenCfg | input | 10 | Terminal count L; the delay is L+3 |
| dIn | input | 16 | Input sample |
| dOut | output | 16 | Delayed sample |

## Verification
The bench feeds a strictly increasing nonzero count. A wrong delay then shows up as an off-by-n value, and a leak of stale or unfilled data shows up as a nonzero value where zero is expected. It runs this count at the minimum length, at small and mid lengths, and at the maximum length, which separates a wrong terminal compare from a wrong fixed overhead. An irregular enable pattern checks that idle cycles neither advance nor corrupt the sweep. A length change made while the enable is low checks that a restart does not wait for an enabled cycle, and that the refill window is exactly L+3 zeros.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int PIPE_LAT = 3;

  typedef struct packed {
    logic adv;        // take one sample this edge
    logic restart;    // length changed: flush history
    logic readValid;  // memory has been swept once since restart
  } sdlStrobe_t;
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [LEN_W-1:0] lenCfg,
  output logic [LEN_W-1:0] addr,
  output sdlStrobe_t       strobe
);
  logic [LEN_W-1:0] lenReg;
  logic             wrapped;
  logic             lenDiff;
  logic             atEnd;

  assign lenDiff = (lenCfg != lenReg);
  assign atEnd   = (addr == lenReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      addr    <= '0;
      wrapped <= 1'b0;
    end else if (lenDiff) begin
      lenReg  <= lenCfg;
      addr    <= '0;
      wrapped <= 1'b0;
    end else if (en) begin
      if (atEnd) begin
        addr    <= '0;
        wrapped <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.restart   = lenDiff;
    strobe.adv       = en && !lenDiff;
    strobe.readValid = wrapped;
  end
endmodule

// File: rtl/sdl_path.sv
module sdl_path
  import sdl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdlStrobe_t        strobe,
  input  logic [LEN_W-1:0]  addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  localparam int DEPTH = 1 << LEN_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dReg;
  logic [DATA_W-1:0] ramQ;
  logic              rdOk;

  // Single port: the old word is read and the new one written on the same edge.
  always_ff @(posedge clk) begin
    if (strobe.adv) mem[addr] <= dReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dReg <= '0;
      ramQ <= '0;
      rdOk <= 1'b0;
      dOut <= '0;
    end else if (strobe.restart) begin
      dReg <= '0;
      rdOk <= 1'b0;
      dOut <= '0;
    end else if (strobe.adv) begin
      dReg <= dIn;
      ramQ <= mem[addr];
      rdOk <= strobe.readValid;
      dOut <= rdOk ? ramQ : '0;
    end
  end
endmodule

// File: rtl/ram_sample_delay.sv
module ram_sample_delay
  import sdl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [LEN_W-1:0]  lenCfg,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  logic [LEN_W-1:0] addr;
  sdlStrobe_t       strobe;

  sdl_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .en     (en),
    .lenCfg (lenCfg),
    .addr   (addr),
    .strobe (strobe)
  );

  sdl_path #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .dIn    (dIn),
    .dOut   (dOut)
  );
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              en,
  input logic [LEN_W-1:0]  lenCfg,
  input logic              restart,
  input logic              wrapped,
  input logic [LEN_W-1:0]  addr,
  input logic [DATA_W-1:0] dOut
);
  // R2: address steps by one and wraps after the terminal count
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (en && !restart) |=> (addr == (($past(addr) == $past(lenCfg)) ? '0
                                   : LEN_W'($past(addr) + 1'b1))));

  // R3: an idle cycle changes nothing visible
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !restart) |=> ($stable(dOut) && $stable(addr)));

  // R5: a length change restarts the sweep and clears the output
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (addr == '0 && !wrapped && dOut == '0));

  // R4: the first sweep after a restart cannot already be marked filled
  a_r4_no_early_fill: assert property (@(posedge clk) disable iff (!rstN)
    (restart || (!wrapped && addr != lenCfg)) |=> !wrapped);

  // R6: reset state
  always @(negedge clk) begin
    if (!rstN) begin
      a_r6_reset_state: assert (dOut == '0 && addr == '0);
    end
  end
endmodule

bind ram_sample_delay sdl_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .en      (en),
  .lenCfg  (lenCfg),
  .restart (strobe.restart),
  .wrapped (strobe.readValid),
  .addr    (addr),
  .dOut    (dOut)
);

// File: tb/tb_ram_sample_delay.sv
module tb_ram_sample_delay;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              en;
  logic [LEN_W-1:0]  lenCfg;
  logic [DATA_W-1:0] dIn;
  logic [DATA_W-1:0] dOut;

  ram_sample_delay #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .en(en), .lenCfg(lenCfg), .dIn(dIn), .dOut(dOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Behavioural reference: history queue of length L+3 holding zeros after a restart
  logic [DATA_W-1:0] hist[$];
  logic [DATA_W-1:0] refOut;
  int                prevLen;
  int                vectors = 0;
  int                fails   = 0;
  int                cycles  = 0;
  bit                checking = 1'b0;
  bit                done = 1'b0;
  string             curReq = "R6";
  int                seq = 0;

  task automatic refill(input int len);
    hist.delete();
    for (int i = 0; i < len + 3; i++) hist.push_back('0);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      prevLen = 0;
      refill(0);
      refOut = '0;
    end else if (int'(lenCfg) != prevLen) begin
      prevLen = int'(lenCfg);
      refill(prevLen);
      refOut = '0;
    end else if (en) begin
      hist.push_back(dIn);
      refOut = hist.pop_front();
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      vectors++;
      if (dOut !== refOut) begin
        fails++;
        $display("FAIL %s: dOut=%0d expected=%0d (len=%0d)", curReq, dOut, refOut, lenCfg);
      end
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic run(input int n, input int enMode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seq++;
      dIn = DATA_W'(seq);
      en  = (enMode == 0) ? 1'b1 : ((i % 3) != 0);
    end
  endtask

  initial begin
    rstN = 1'b0; en = 1'b0; lenCfg = '0; dIn = '0;
    repeat (3) @(negedge clk);
    // R6: reset state at the port
    vectors++;
    if (dOut !== '0) begin
      fails++;
      $display("FAIL R6: dOut=%0d expected=0", dOut);
    end
    checking = 1'b1;
    rstN = 1'b1;

    curReq = "R2";            // smallest length, delay 3
    run(20, 0);
    curReq = "R1";            // L=5, delay 8
    @(negedge clk); en = 1'b0; lenCfg = 10'd5;
    run(30, 0);
    curReq = "R3";            // irregular enable, L=7
    @(negedge clk); en = 1'b0; lenCfg = 10'd7;
    run(60, 1);
    curReq = "R5";            // change while idle
    @(negedge clk); en = 1'b0; lenCfg = 10'd12;
    @(negedge clk);
    vectors++;
    if (dOut !== '0) begin
      fails++;
      $display("FAIL R5: dOut=%0d expected=0 after length change", dOut);
    end
    run(2, 1);
    curReq = "R4";            // refill: 15 zeros then data
    run(40, 0);
    curReq = "R1";            // mid length
    @(negedge clk); en = 1'b0; lenCfg = 10'd300;
    run(700, 0);
    curReq = "R7";            // largest length, delay 1026
    @(negedge clk); en = 1'b0; lenCfg = 10'd1023;
    run(2200, 0);
    @(negedge clk);
    checking = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule